// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block merges six reset requests into a single synchronous system reset. The requests are an active-low external reset pin, a supply-monitor request, a missing-clock request, an active-low comparator output, a watchdog timeout, and a flash access violation. The block detects the flash violation itself by comparing the address of each fetch, table read or write/erase against a parameterized user-code limit. After every reset the block holds a stretched reset pulse for at least a fixed number of cycles. It then releases the pulse on a clock edge. An 8-bit flag register records the single source that started the last reset.

Software reads the flag register through a simple write/read port. Writing to the flag register does not change the flags. Instead, the written value sets the enables of the optional sources: the supply monitor, the missing-clock detector and the comparator. When software turns the supply monitor on, a reset follows at once. The block holds no bidirectional pin, so internal sources never drive the external reset line. An asynchronous power-on input puts the block in its initial state.

Top module: `rst_hub`

## Requirements
- R1: While `por_n` is low, `sys_rst` is high. After `por_n` rises, `sys_rst` falls within 20 cycles. The flag register then reads 0x02 (bit 1, the power/supply cause) and all enables are cleared.
- R2: A low level on `pin_n` causes a reset after a two-flop synchronizer. Afterwards only flag bit 0 is set.
- R3: On reset entry exactly one cause flag is set and all other flags are cleared. The flag positions are: pin bit 0, supply bit 1, missing clock bit 2, watchdog bit 3, comparator bit 5 and flash error bit 6. When several sources are active in the same cycle, the priority is pin > supply > missing clock > comparator > watchdog > flash.
- R4: `sys_rst` stays high for STRETCH−1 cycles plus the number of cycles that any request is seen active, so a one-cycle request gives exactly 16 cycles. It deasserts on a clock edge.
- R5: Any register write sets three enables from the written bits: bit 1 sets the supply enable, bit 2 the missing-clock enable and bit 5 the comparator enable. Writes never alter the flags. Writes made while `sys_rst` is high are ignored.
- R6: Writing 1 to bit 1 while the supply enable is 0 causes a reset with cause flag bit 1 and leaves the supply enable set. Writing 1 to bit 1 while the supply enable is already 1 causes no reset.
- R7: The missing-clock request and the comparator cause a reset only when enabled. The comparator request is active when `cmp_out` is low, after a two-flop synchronizer.
- R8: The watchdog timeout always causes a reset with flag bit 3.
- R9: An access above LIMIT raises a flash-error reset (flag bit 6). The access type is given by `fa_kind`: 0 is a fetch, 1 a table read, and 2 a write/erase that counts only when `flash_wr_en` is 1. An access at or below LIMIT, a write with `flash_wr_en` at 0, and `fa_kind` 3 are all ignored.
- R10: The enables keep their values across every reset except power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_n | input | 1 | External reset pin level, active low, asynchronous |
| sup_req | input | 1 | Supply-monitor request, active high |
| mcd_req | input | 1 | Missing-clock request, active high |
| cmp_out | input | 1 | Comparator output, low requests reset, asynchronous |
| wdt_req | input | 1 | Watchdog timeout, active high |
| fa_valid | input | 1 | Flash access in progress |
| fa_kind | input | 2 | Access type: 0 fetch, 1 table read, 2 write/erase, 3 none |
| fa_addr | input | AW | Flash access address |
| flash_wr_en | input | 1 | Flash write/erase enable bit |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data (enables in bits 1, 2, 5) |
| reg_rdata | output | 8 | Cause flag register |
| sys_rst | output | 1 | Synchronous system reset, active high |

## Verification
The hardest case to reach is the priority decision. For it to be tested, several sources must be active in the very same cycle, but the pin and comparator inputs pass through synchronizers while the other inputs do not. The stimulus therefore draws random non-empty subsets from within one timing group: either the unsynchronized supply, missing-clock, watchdog and flash requests, or the synchronized pin and comparator. It also draws random hold lengths, so both the winning flag and the stretched pulse length are predicted. A second hard case is a register write landing during a reset. The stimulus starts a watchdog reset, writes during the pulse, and then shows through the comparator that the enable was not touched.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
    // request index order equals priority order (index 0 wins)
    localparam int NSRC = 6;
    localparam int S_PIN = 0;
    localparam int S_SUP = 1;
    localparam int S_MCD = 2;
    localparam int S_CMP = 3;
    localparam int S_WDT = 4;
    localparam int S_FLS = 5;

    // flag register bit positions
    localparam int F_PIN = 0;
    localparam int F_SUP = 1;
    localparam int F_MCD = 2;
    localparam int F_WDT = 3;
    localparam int F_CMP = 5;
    localparam int F_FLS = 6;
    localparam logic [7:0] FLAG_MASK = 8'b0110_1111;
    localparam logic [7:0] POR_FLAGS = 8'h02;

    typedef enum logic [1:0] {
        FA_FETCH = 2'd0,
        FA_TABLE = 2'd1,
        FA_WRITE = 2'd2,
        FA_NONE  = 2'd3
    } fa_kind_e;

    function automatic int flag_pos(input int src);
        case (src)
            S_PIN:   return F_PIN;
            S_SUP:   return F_SUP;
            S_MCD:   return F_MCD;
            S_CMP:   return F_CMP;
            S_WDT:   return F_WDT;
            default: return F_FLS;
        endcase
    endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '1
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= INIT;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import rst_hub_pkg::*;
#(
    parameter int            AW    = 16,
    parameter logic [AW-1:0] LIMIT = 16'h1DFF
) (
    input  logic          fa_valid,
    input  logic [1:0]    fa_kind,
    input  logic [AW-1:0] fa_addr,
    input  logic          flash_wr_en,
    output logic          viol
);
    logic above;
    logic counts;

    always_comb begin
        above = fa_addr > LIMIT;
        case (fa_kind_e'(fa_kind))
            FA_FETCH: counts = 1'b1;
            FA_TABLE: counts = 1'b1;
            FA_WRITE: counts = flash_wr_en;
            default:  counts = 1'b0;
        endcase
        viol = fa_valid && above && counts;
    end
endmodule

// File: rtl/cause_pick.sv
module cause_pick
    import rst_hub_pkg::*;
(
    input  logic [NSRC-1:0] act,
    output logic            any,
    output logic [7:0]      flags
);
    always_comb begin
        any   = |act;
        flags = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) begin
                flags = '0;
                flags[flag_pos(i)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_hub.sv
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] LIMIT   = 16'h1DFF,
    parameter int            STRETCH = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          pin_n,
    input  logic          sup_req,
    input  logic          mcd_req,
    input  logic          cmp_out,
    input  logic          wdt_req,
    input  logic          fa_valid,
    input  logic [1:0]    fa_kind,
    input  logic [AW-1:0] fa_addr,
    input  logic          flash_wr_en,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          sys_rst
);
    localparam int CW = (STRETCH > 2) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(STRETCH - 1);

    typedef struct packed {
        logic          rst;
        logic [CW-1:0] cnt;
        logic [7:0]    flags;
        logic          sup_en;
        logic          mcd_en;
        logic          cmp_en;
    } state_t;

    state_t state_d, state_q;

    logic [1:0]      sync_out;
    logic            pin_low, cmp_low, flash_viol;
    logic            sup_arm, any_act;
    logic [NSRC-1:0] act;
    logic [7:0]      pick_flags;
    logic            unused_wbits;

    assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[4:3], reg_wdata[0]};

    rst_sync #(.W(2), .STAGES(2), .INIT(2'b11)) u_sync (
        .clk  (clk),
        .por_n(por_n),
        .din  ({cmp_out, pin_n}),
        .dout (sync_out)
    );

    assign pin_low = ~sync_out[0];
    assign cmp_low = ~sync_out[1];

    flash_guard #(.AW(AW), .LIMIT(LIMIT)) u_guard (
        .fa_valid   (fa_valid),
        .fa_kind    (fa_kind),
        .fa_addr    (fa_addr),
        .flash_wr_en(flash_wr_en),
        .viol       (flash_viol)
    );

    always_comb begin
        sup_arm        = reg_we && reg_wdata[F_SUP] && !state_q.sup_en && !state_q.rst;
        act            = '0;
        act[S_PIN]     = pin_low;
        act[S_SUP]     = (sup_req && state_q.sup_en) || sup_arm;
        act[S_MCD]     = mcd_req && state_q.mcd_en;
        act[S_CMP]     = cmp_low && state_q.cmp_en;
        act[S_WDT]     = wdt_req;
        act[S_FLS]     = flash_viol;
    end

    cause_pick u_pick (
        .act  (act),
        .any  (any_act),
        .flags(pick_flags)
    );

    always_comb begin
        state_d = state_q;
        if (!state_q.rst && reg_we) begin
            state_d.sup_en = reg_wdata[F_SUP];
            state_d.mcd_en = reg_wdata[F_MCD];
            state_d.cmp_en = reg_wdata[F_CMP];
        end
        if (any_act) begin
            if (!state_q.rst) begin
                state_d.rst   = 1'b1;
                state_d.flags = pick_flags;
            end
            state_d.cnt = CNT_TOP;
        end else if (state_q.rst) begin
            if (state_q.cnt != '0) state_d.cnt = state_q.cnt - 1'b1;
            else                   state_d.rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q.rst    <= 1'b1;
            state_q.cnt    <= CNT_TOP;
            state_q.flags  <= POR_FLAGS;
            state_q.sup_en <= 1'b0;
            state_q.mcd_en <= 1'b0;
            state_q.cmp_en <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.flags;
    assign sys_rst   = state_q.rst;

    // checker-only count of cycles spent in reset
    logic [CW:0] held_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 held_q <= '0;
        else if (!state_q.rst)      held_q <= '0;
        else if (held_q != '1)      held_q <= held_q + 1'b1;
    end

    a_r4_min_stretch: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (held_q >= (CW+1)'(STRETCH - 1)));

    a_r3_single_flag: assert property (@(posedge clk) disable iff (!por_n)
        $onehot(reg_rdata & FLAG_MASK) && ((reg_rdata & ~FLAG_MASK) == 8'h00));

    a_r2_pin_wins: assert property (@(posedge clk) disable iff (!por_n)
        (pin_low && !sys_rst) |=> (sys_rst && reg_rdata == 8'h01));

    a_r9_flash_resets: assert property (@(posedge clk) disable iff (!por_n)
        flash_viol |=> sys_rst);

    a_r5_write_in_reset_ignored: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && reg_we) |=> $stable({state_q.sup_en, state_q.mcd_en, state_q.cmp_en}));
endmodule

// File: tb/rst_hub_bench.sv
module rst_hub_bench;
    localparam int AW = 16;
    localparam logic [AW-1:0] LIMIT = 16'h1DFF;

    logic clk = 0;
    logic por_n, pin_n, sup_req, mcd_req, cmp_out, wdt_req;
    logic fa_valid, flash_wr_en, reg_we;
    logic [1:0] fa_kind;
    logic [AW-1:0] fa_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sys_rst;

    int n_chk = 0, n_bad = 0, hi_total = 0;

    always #5 clk = ~clk;
    always @(negedge clk) if (sys_rst) hi_total++;

    rst_hub #(.AW(AW), .LIMIT(LIMIT), .STRETCH(16)) u_rst_hub (
        .clk(clk), .por_n(por_n), .pin_n(pin_n), .sup_req(sup_req),
        .mcd_req(mcd_req), .cmp_out(cmp_out), .wdt_req(wdt_req),
        .fa_valid(fa_valid), .fa_kind(fa_kind), .fa_addr(fa_addr),
        .flash_wr_en(flash_wr_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pin_n = 1; sup_req = 0; mcd_req = 0; cmp_out = 1; wdt_req = 0;
        fa_valid = 0; fa_kind = 2'd3; fa_addr = '0; flash_wr_en = 0;
        reg_we = 0; reg_wdata = 8'h00;
    endtask

    // src bits: 0 pin, 1 supply, 2 missing clock, 3 comparator, 4 watchdog, 5 flash
    task automatic drive(input logic [5:0] src, input int hold);
        @(negedge clk);
        pin_n = ~src[0]; sup_req = src[1]; mcd_req = src[2];
        cmp_out = ~src[3]; wdt_req = src[4];
        if (src[5]) begin fa_valid = 1; fa_kind = 2'd0; fa_addr = LIMIT + 1; end
        repeat (hold) @(negedge clk);
        idle();
    endtask

    function automatic int win_flag(input logic [5:0] src);
        int pos [6] = '{0, 1, 2, 5, 3, 6};
        for (int i = 0; i < 6; i++) if (src[i]) return 1 << pos[i];
        return 0;
    endfunction

    task automatic settle(output int hi, input int start);
        repeat (40) @(negedge clk);
        hi = hi_total - start;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_we = 1; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic expect_none(input string tag, input int flags_before, input int start);
        int hi;
        settle(hi, start);
        chk({tag, " pulse"}, hi, 0);
        chk({tag, " flags"}, reg_rdata, flags_before);
    endtask

    task automatic expect_reset(input string tag, input int flag, input int pulse, input int start);
        int hi;
        settle(hi, start);
        chk({tag, " pulse"}, hi, pulse);
        chk({tag, " flags"}, reg_rdata, flag);
    endtask

    task automatic por_pulse();
        @(negedge clk); por_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 held during por", sys_rst, 1);
        por_n = 1;
        repeat (20) @(negedge clk);
        chk("R1 released", sys_rst, 0);
        chk("R1 por flags", reg_rdata, 8'h02);
    endtask

    initial begin
        #(2_000_000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s, f;
        void'($urandom(32'd13));
        idle(); por_n = 0;
        repeat (2) @(negedge clk);
        por_pulse();

        // R6: enabling supply monitor resets; enables 1,2,5 set by same write
        s = hi_total; wr(8'h26); expect_reset("R6 enable supply", 8'h02, 16, s);
        s = hi_total; wr(8'h26); expect_none("R6 already enabled", 8'h02, s);
        // R5: flag bits are read-only
        s = hi_total; wr(8'hFF); expect_none("R5 flags read-only", 8'h02, s);

        // R2 R3 R4 R7 R8 R9: random same-group collisions
        for (int it = 0; it < 40; it++) begin
            logic [5:0] src;
            int hold;
            src = '0;
            hold = 1 + int'($urandom % 4);
            if ($urandom % 2 == 0) begin
                while (src == 0) begin
                    src[1] = $urandom % 2; src[2] = $urandom % 2;
                    src[4] = $urandom % 2; src[5] = $urandom % 2;
                end
            end else begin
                while (src == 0) begin
                    src[0] = $urandom % 2; src[3] = $urandom % 2;
                end
            end
            s = hi_total; drive(src, hold);
            expect_reset("R3 R4 priority/stretch", win_flag(src), hold + 15, s);
        end

        // R8 watchdog single pulse, R4 minimum length
        s = hi_total; drive(6'b010000, 1); expect_reset("R8 watchdog", 8'h08, 16, s);
        // R2 pin held low longer
        s = hi_total; drive(6'b000001, 6); expect_reset("R2 pin held", 8'h01, 21, s);

        // R9 flash boundaries
        f = reg_rdata;
        s = hi_total; @(negedge clk); fa_valid = 1; fa_kind = 2'd0; fa_addr = LIMIT;
        @(negedge clk); idle(); expect_none("R9 fetch at limit", f, s);
        s = hi_total; @(negedge clk); fa_valid = 1; fa_kind = 2'd1; fa_addr = LIMIT + 1;
        @(negedge clk); idle(); expect_reset("R9 table above", 8'h40, 16, s);
        s = hi_total; @(negedge clk); fa_valid = 1; fa_kind = 2'd2; fa_addr = 16'hFFFF; flash_wr_en = 0;
        @(negedge clk); idle(); expect_none("R9 write no enable", 8'h40, s);
        s = hi_total; drive(6'b000100, 1); expect_reset("R7 mcd enabled", 8'h04, 16, s);
        s = hi_total; @(negedge clk); fa_valid = 1; fa_kind = 2'd2; fa_addr = LIMIT + 1; flash_wr_en = 1;
        @(negedge clk); idle(); expect_reset("R9 write enabled", 8'h40, 16, s);
        s = hi_total; @(negedge clk); fa_valid = 1; fa_kind = 2'd3; fa_addr = 16'hFFFF; flash_wr_en = 1;
        @(negedge clk); idle(); expect_none("R9 kind none", 8'h40, s);

        // R7: disabled sources ignored
        s = hi_total; wr(8'h02); expect_none("R7 disable write", 8'h40, s);
        s = hi_total; drive(6'b000100, 3); expect_none("R7 mcd disabled", 8'h40, s);
        s = hi_total; drive(6'b001000, 3); expect_none("R7 cmp disabled", 8'h40, s);

        // R5: write during reset ignored
        wr(8'h26);
        s = hi_total;
        @(negedge clk); wdt_req = 1; @(negedge clk); wdt_req = 0;
        repeat (4) @(negedge clk);
        chk("R5 in reset", sys_rst, 1);
        reg_we = 1; reg_wdata = 8'h02; @(negedge clk); reg_we = 0;
        expect_reset("R5 wdt around write", 8'h08, 16, s);
        s = hi_total; drive(6'b001000, 1); expect_reset("R5 R10 cmp still enabled", 8'h20, 16, s);

        // R10: power-on clears enables
        por_pulse();
        s = hi_total; drive(6'b000100, 2); expect_none("R10 mcd after por", 8'h02, s);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule